// File: doc/BRIEF.md
# Oscillator Trim Controller

This block keeps an on-chip oscillator close to its target frequency by measuring it against a slow, accurate reference. The reference signal arrives asynchronously. It is brought into the system clock domain through a two-stage synchronizer, and each of its rising edges becomes a one-cycle tick. A programmable number of ticks forms a measurement window. During the window, a saturating counter counts system-clock cycles.

When a window closes, the count is compared with an expected value and a symmetric tolerance band. If the count is above the band, the oscillator runs fast and the trim code steps down. If it is below the band, the oscillator runs slow and the trim code steps up. If it is inside the band, the trim code is left alone. Both counters then restart for the next window.

Each closed window produces one update strobe, together with a two-bit verdict. The trim code is a signed value centred on zero that stops at its end values. The oscillator itself is not part of the block. It simply consumes `trim_o`.

Top module: `osc_trim_ctrl`

## Requirements
- R1: While reset is asserted and after its release, before any window closes: `trim_o` is 0, `status_o` is 2'b00 and `upd_o` is low.
- R2: `ref_i` is sampled through two flops, and a rising edge of the synchronized signal gives one tick. A window closes on its `win_len_i`-th tick, with a value of 0 acting as 1. `upd_o` pulses high for exactly one cycle, one cycle after the closing tick, once per window.
- R3: The measured count of a window equals the number of system-clock cycles between its closing tick and the previous closing tick. With ticks every T cycles and a window length W, this is W*T.
- R4: If the count exceeds `exp_cnt_i + tol_i`, `status_o` becomes 2'b01 (fast) and `trim_o` decreases by one.
- R5: If the count is below `exp_cnt_i - tol_i`, `status_o` becomes 2'b10 (slow) and `trim_o` increases by one. When `tol_i` exceeds `exp_cnt_i`, no window is ever judged slow.
- R6: If the count lies within the inclusive band `exp_cnt_i - tol_i` to `exp_cnt_i + tol_i`, `status_o` becomes 2'b00 (ok) and `trim_o` keeps its value.
- R7: `trim_o` is two's complement. 5'b01111 is the highest frequency, 5'b00000 the centre and 5'b10000 the lowest. A step up at 5'b01111 or a step down at 5'b10000 leaves the code unchanged.
- R8: The cycle counter stops at all ones instead of wrapping. A window longer than its range therefore reads as the maximum count.
- R9: `trim_o` and `status_o` change only in the cycle in which `upd_o` is high, and `status_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, driven by the oscillator being trimmed |
| rst_ni | input | 1 | Active-low reset |
| ref_i | input | 1 | Asynchronous slow reference clock |
| win_len_i | input | WIN_W | Reference ticks per measurement window (0 acts as 1) |
| exp_cnt_i | input | CNT_W | Expected system-clock cycles per window |
| tol_i | input | CNT_W | Allowed deviation either side of the expected count |
| trim_o | output | TRIM_W | Signed trim code for the oscillator |
| status_o | output | 2 | Verdict of the last window: 00 ok, 01 fast, 10 slow |
| upd_o | output | 1 | One-cycle strobe marking a new verdict and trim |

## Verification
The bench builds the block with CNT_W=10 and WIN_W=5. With a 10-bit counter, a 20-tick window on a 64-cycle reference overruns the counter range. The saturated count is then judged fast, where a wrapped count would have looked slow.

The 5-bit window field allows both very short windows and length 0, so long runs of slow and fast verdicts drive the trim code into both of its end values within a few thousand cycles. Exact band edges and a tolerance larger than the expected value are each set up with 128-cycle and 32-cycle windows.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    typedef enum logic [1:0] {
        ST_OK   = 2'b00,
        ST_FAST = 2'b01,
        ST_SLOW = 2'b10
    } trim_status_e;

endpackage

// File: rtl/otc_ref_sync.sv
// Two-flop synchronizer for the reference, plus a rising-edge detector.
module otc_ref_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic tick_o
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], ref_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // sh_q[1] is the synchronized level, sh_q[2] holds it one cycle later.
    assign tick_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/otc_window.sv
// Counts reference ticks and flags the tick that closes a window.
module otc_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             win_end_o
);
    localparam logic [WIN_W:0] ONE_X = (WIN_W+1)'(1);

    logic [WIN_W-1:0] cnt_d, cnt_q;
    logic             last;

    // A length of 0 makes last true on every tick, so it acts as 1.
    assign last      = ({1'b0, cnt_q} + ONE_X) >= {1'b0, win_len_i};
    assign win_end_o = tick_i & last;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            if (last) cnt_d = '0;
            else      cnt_d = cnt_q + WIN_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/otc_sys_counter.sv
// Saturating system-clock counter. On restart it loads 1, because the
// cycle that closes a window is counted as the first cycle of the next one.
module otc_sys_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i)              cnt_d = CNT_W'(1);
        else if (cnt_q == CNT_MAX)  cnt_d = cnt_q;
        else                        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/otc_trim_step.sv
// Judges each closed window and steps the saturating trim code.
module otc_trim_step
    import osc_trim_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TRIM_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              win_end_i,
    input  logic [CNT_W-1:0]  sample_i,
    input  logic [CNT_W-1:0]  exp_cnt_i,
    input  logic [CNT_W-1:0]  tol_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic [1:0]        status_o,
    output logic              upd_o
);
    localparam logic [TRIM_W-1:0] TRIM_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic [TRIM_W-1:0] TRIM_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic [TRIM_W-1:0] TRIM_ONE = TRIM_W'(1);

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic [1:0]        status;
        logic              upd;
    } step_t;

    step_t st_d, st_q;

    logic [CNT_W:0] samp_x, hi_x, lo_sum_x;
    logic           is_fast, is_slow;

    // One extra bit keeps exp+tol from overflowing. Comparing sample+tol
    // against exp avoids subtracting, so a large tol cannot underflow.
    assign samp_x   = {1'b0, sample_i};
    assign hi_x     = {1'b0, exp_cnt_i} + {1'b0, tol_i};
    assign lo_sum_x = samp_x + {1'b0, tol_i};
    assign is_fast  = samp_x > hi_x;
    assign is_slow  = lo_sum_x < {1'b0, exp_cnt_i};

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (win_end_i) begin
            st_d.upd = 1'b1;
            if (is_fast) begin
                st_d.status = ST_FAST;
                if (st_q.trim != TRIM_MIN) st_d.trim = st_q.trim - TRIM_ONE;
            end else if (is_slow) begin
                st_d.status = ST_SLOW;
                if (st_q.trim != TRIM_MAX) st_d.trim = st_q.trim + TRIM_ONE;
            end else begin
                st_d.status = ST_OK;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{trim: '0, status: ST_OK, upd: 1'b0};
        else         st_q <= st_d;
    end

    assign trim_o   = st_q.trim;
    assign status_o = st_q.status;
    assign upd_o    = st_q.upd;
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 8,
    parameter int TRIM_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_i,
    input  logic [WIN_W-1:0]  win_len_i,
    input  logic [CNT_W-1:0]  exp_cnt_i,
    input  logic [CNT_W-1:0]  tol_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic [1:0]        status_o,
    output logic              upd_o
);
    logic             ref_tick;
    logic             win_end;
    logic [CNT_W-1:0] sys_cnt;

    otc_ref_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_i),
        .tick_o (ref_tick)
    );

    otc_window #(.WIN_W(WIN_W)) u_window (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (ref_tick),
        .win_len_i (win_len_i),
        .win_end_o (win_end)
    );

    otc_sys_counter #(.CNT_W(CNT_W)) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (win_end),
        .cnt_o     (sys_cnt)
    );

    otc_trim_step #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_step (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .win_end_i (win_end),
        .sample_i  (sys_cnt),
        .exp_cnt_i (exp_cnt_i),
        .tol_i     (tol_i),
        .trim_o    (trim_o),
        .status_o  (status_o),
        .upd_o     (upd_o)
    );
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
    parameter int CNT_W  = 16,
    parameter int TRIM_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_end,
    input logic [CNT_W-1:0]  sys_cnt,
    input logic [TRIM_W-1:0] trim,
    input logic [1:0]        status,
    input logic              upd
);
    localparam logic [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic [TRIM_W-1:0] T_ONE = TRIM_W'(1);
    localparam logic [CNT_W-1:0]  C_MAX = '1;

    assert_strobe_after_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> upd);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    assert_fast_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && status == 2'b01) |->
            ((trim == $past(trim) - T_ONE) || ($past(trim) == T_MIN && trim == T_MIN)));

    assert_slow_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && status == 2'b10) |->
            ((trim == $past(trim) + T_ONE) || ($past(trim) == T_MAX && trim == T_MAX)));

    assert_ok_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && status == 2'b00) |-> $stable(trim));

    assert_counter_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_cnt == C_MAX && !win_end) |=> (sys_cnt == C_MAX));

    assert_quiet_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> ($stable(trim) && $stable(status)));

    assert_status_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) chk_i (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .win_end (win_end),
    .sys_cnt (sys_cnt),
    .trim    (trim_o),
    .status  (status_o),
    .upd     (upd_o)
);

// File: tb/osc_trim_ctrl_tb_top.sv
`timescale 1ns/1ps
module osc_trim_ctrl_tb_top;
    localparam int CNT_W  = 10;
    localparam int WIN_W  = 5;
    localparam int TRIM_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_s = 1'b0;
    logic [WIN_W-1:0]  win_len = '0;
    logic [CNT_W-1:0]  exp_cnt = '0;
    logic [CNT_W-1:0]  tol = '0;
    logic [TRIM_W-1:0] trim;
    logic [1:0]        status;
    logic              upd;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;

    typedef struct {
        bit         skip;
        logic [1:0] st;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    osc_trim_ctrl #(.CNT_W(CNT_W), .WIN_W(WIN_W), .TRIM_W(TRIM_W)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ref_i     (ref_s),
        .win_len_i (win_len),
        .exp_cnt_i (exp_cnt),
        .tol_i     (tol),
        .trim_o    (trim),
        .status_o  (status),
        .upd_o     (upd)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // The window in progress when a phase starts mixes old and new
    // settings, so its verdict is unknown and it is queued as a skip item.
    task automatic run_phase(input int t, input int w, input int e, input int tl,
                             input int n, input string tag);
        int weff;
        int cnt;
        exp_t it;
        weff = (w == 0) ? 1 : w;
        cnt  = weff * t;
        if (cnt > (1 << CNT_W) - 1) cnt = (1 << CNT_W) - 1;   // R8 saturation
        @(negedge clk);
        win_len = WIN_W'(w);
        exp_cnt = CNT_W'(e);
        tol     = CNT_W'(tl);
        it.skip = 1'b1; it.st = 2'b00; it.tag = tag;
        sb_q.push_back(it);
        for (int i = 0; i < n; i++) begin
            it.skip = 1'b0;
            it.tag  = tag;
            if (cnt > e + tl)      it.st = 2'b01;
            else if (cnt < e - tl) it.st = 2'b10;
            else                   it.st = 2'b00;
            sb_q.push_back(it);
        end
        for (int p = 0; p < (n + 1) * weff; p++) begin
            ref_s = 1'b1;
            repeat (t / 2) @(negedge clk);
            ref_s = 1'b0;
            repeat (t - t / 2) @(negedge clk);
        end
    endtask

    // Monitor: pops one expected item per strobe and follows the trim.
    initial begin : monitor
        int model = 0;
        logic [TRIM_W-1:0] last_trim = '0;
        logic [1:0] last_st = 2'b00;
        bit prev_upd = 1'b0;
        logic [1:0] use_st;
        exp_t it;
        wait (mon_on);
        forever begin
            @(negedge clk);
            if (!upd && (trim !== last_trim || status !== last_st)) begin
                checks++; failures++;
                $display("FAIL R9 outputs moved without strobe: trim=%0d status=%0d expected trim=%0d status=%0d",
                         trim, status, last_trim, last_st);
            end
            if (upd) begin
                checks++;
                if (prev_upd) begin
                    failures++;
                    $display("FAIL R2 strobe longer than one cycle: upd=1 expected 0");
                end
                if (sb_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R2 unexpected strobe: status=%0d expected no update", status);
                    use_st = status;
                end else begin
                    it = sb_q.pop_front();
                    if (it.skip) begin
                        checks++;
                        if (status == 2'b11) begin
                            failures++;
                            $display("FAIL R9 %s illegal status: actual=%0d expected 0..2", it.tag, status);
                        end
                        use_st = status;
                    end else begin
                        checks++;
                        if (status !== it.st) begin
                            failures++;
                            $display("FAIL %s status: actual=%0d expected=%0d", it.tag, status, it.st);
                        end
                        use_st = it.st;
                    end
                end
                if (use_st == 2'b01 && model > -16) model--;
                if (use_st == 2'b10 && model < 15)  model++;
                checks++;
                if ($signed(trim) != model) begin
                    failures++;
                    $display("FAIL R7 trim code: actual=%0d expected=%0d", $signed(trim), model);
                end
                last_trim = trim;
                last_st   = status;
            end
            prev_upd = upd;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog expired: pending=%0d expected 0", sb_q.size());
        summary();
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        checks++;
        if (trim !== '0 || status !== 2'b00 || upd !== 1'b0) begin
            failures++;
            $display("FAIL R1 in reset: trim=%0d status=%0d upd=%0d expected 0 0 0", trim, status, upd);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        checks++;
        if (trim !== '0 || status !== 2'b00 || upd !== 1'b0) begin
            failures++;
            $display("FAIL R1 after reset: trim=%0d status=%0d upd=%0d expected 0 0 0", trim, status, upd);
        end
        mon_on = 1'b1;

        run_phase(16, 2, 100, 4, 20, "R5 slow to ceiling");       // 32 < 96
        run_phase(16, 8, 100, 4, 34, "R4 fast to floor");         // 128 > 104
        run_phase(16, 8, 128, 0, 2,  "R6 exact match");
        run_phase(16, 8, 124, 4, 2,  "R6 upper edge inside");
        run_phase(16, 8, 123, 4, 2,  "R4 upper edge outside");
        run_phase(16, 8, 132, 4, 2,  "R6 lower edge inside");
        run_phase(16, 8, 133, 4, 2,  "R5 lower edge outside");
        run_phase(16, 2, 40, 50, 2,  "R5 tol above expected");    // 32 stays ok
        run_phase(20, 0, 20, 0, 3,   "R2 zero length window");
        run_phase(20, 0, 25, 2, 2,   "R2 zero length slow");
        run_phase(24, 3, 72, 1, 2,   "R3 count is W*T");
        run_phase(64, 20, 1000, 10, 2, "R8 saturated count");     // 1023 > 1010

        while (sb_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        summary();
        $finish;
    end
endmodule